// File: doc/BRIEF.md
# Product-Term Logic Macrocell

This block is one configurable logic cell of the kind found in product-term programmable devices. Four logic inputs are each offered to a small AND array in both polarities. The array has eight columns and five product terms, and each product term is the AND of the columns whose configuration bit is set. A selection stage ORs any chosen subset of the terms into a sum-of-products result. That result either drives the output directly or passes through a D flip-flop. The flip-flop clock can come from the global clock or from a product term, and its asynchronous clear can come from the global clear line or from another product term.

The cell output is also driven on a separate feedback port, so that an interconnect can route it to other cells. The configuration is held in a 48-bit vector. A serial loader fills a shadow register while a load enable is high, and the live configuration changes only after the enable falls, so the cell never runs with a half-shifted setup. Global product term 3 serves as the local clock and product term 4 as the local clear when those sources are selected.

Top module: `ptl_macrocell`

## Requirements
- R1: Array column 2i carries input pin_in[i] and column 2i+1 carries its inverse, for i = 0..3 (A = pin_in[0], B = pin_in[1], C = pin_in[2], D = pin_in[3]).
- R2: Product term p is the AND of the columns whose mask bit is set. Mask bit for term p, column c sits at configuration bit p*8+c. A term with no mask bit set evaluates to 0.
- R3: The sum is the OR of the terms whose select bit is set (configuration bits 40..44, bit 40+p for term p). With no select bit set the sum is 0.
- R4: With the bypass bit (configuration bit 47) at 1, cell_out equals the sum combinationally, with no clock needed.
- R5: With bypass at 0 and the clock-source bit (bit 45) at 0, the flip-flop loads the sum on a rising edge of clk and holds it between edges.
- R6: With the clock-source bit at 1, the flip-flop loads the sum on a rising edge of product term 3, and edges of clk have no effect on it.
- R7: With the clear-source bit (bit 46) at 0, glb_clr high forces the flip-flop to 0 at once, without waiting for a clock edge, and holds it there while high.
- R8: With the clear-source bit at 1, product term 4 high clears the flip-flop asynchronously and glb_clr has no effect.
- R9: fb_out always carries the same value as cell_out.
- R10: While cfg_load_en is high, cfg_sdi is shifted in on each rising clk edge, most significant configuration bit first, and the live configuration does not change. The shifted vector becomes live on the first rising clk edge at which cfg_load_en is low after having been high.
- R11: rst high on a rising clk edge clears the shadow and live configuration to all zeros, after which the registered output settles to 0.
- R12: The configuration can realise f = A·C·!D + B·C·!D with two product terms, matching f for all 16 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; also clocks the configuration loader |
| rst | input | 1 | Synchronous active-high reset of the configuration loader |
| cfg_load_en | input | 1 | High while configuration bits are being shifted in |
| cfg_sdi | input | 1 | Serial configuration data, most significant bit first |
| pin_in | input | 4 | Logic inputs A..D of the cell |
| glb_clr | input | 1 | Global asynchronous active-high clear |
| cell_out | output | 1 | Registered or bypassed sum-of-products result |
| fb_out | output | 1 | Copy of the cell result for the interconnect |

## Verification
The bench uses the default build of four inputs and five product terms, which gives a 48-bit configuration. At that size every one of the sixteen input combinations of the two-term example function can be checked exhaustively in bypass mode. Both reserved terms, the local clock and the local clear, are reachable from inputs that do not feed the sum term. This lets the bench move the sum first and fire a local clock or clear edge afterwards, so that each edge captures or clears a known value. Reloading the configuration serially between tests exercises the shadow-then-apply path, including a check that the old function persists part-way through a load.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
    parameter int N_IN  = 4;
    parameter int N_PT  = 5;
    localparam int N_COL  = 2 * N_IN;
    localparam int CLK_PT = N_PT - 2;
    localparam int CLR_PT = N_PT - 1;

    typedef struct packed {
        logic                            bypass;
        logic                            clr_sel;
        logic                            clk_sel;
        logic [N_PT-1:0]                 or_sel;
        logic [N_PT-1:0][N_COL-1:0]      and_mask;
    } ptl_cfg_t;

    localparam int CFG_W = $bits(ptl_cfg_t);

    function automatic logic [N_COL-1:0] expand_cols(input logic [N_IN-1:0] x);
        logic [N_COL-1:0] c;
        for (int i = 0; i < N_IN; i++) begin
            c[2*i]   = x[i];
            c[2*i+1] = ~x[i];
        end
        return c;
    endfunction
endpackage

// File: rtl/ptl_cfg_loader.sv
module ptl_cfg_loader
    import ptl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_en,
    input  logic     sdi,
    output ptl_cfg_t act_cfg
);
    logic [CFG_W-1:0] shadow;
    logic             load_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow    <= '0;
            load_en_q <= 1'b0;
            act_cfg   <= '0;
        end else begin
            load_en_q <= load_en;
            if (load_en) begin
                shadow <= {shadow[CFG_W-2:0], sdi};
            end
            if (!load_en && load_en_q) begin
                act_cfg <= ptl_cfg_t'(shadow);
            end
        end
    end
endmodule

// File: rtl/ptl_and_array.sv
module ptl_and_array
    import ptl_pkg::*;
(
    input  logic [N_IN-1:0]             pin_in,
    input  logic [N_PT-1:0][N_COL-1:0]  mask,
    output logic [N_PT-1:0]             pt
);
    logic [N_COL-1:0] cols;

    assign cols = expand_cols(pin_in);

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic any_link;
        logic all_true;
        assign any_link = |mask[p];
        assign all_true = &(cols | ~mask[p]);
        assign pt[p]    = any_link & all_true;
    end
endmodule

// File: rtl/ptl_or_plane.sv
module ptl_or_plane
    import ptl_pkg::*;
(
    input  logic [N_PT-1:0] pt,
    input  logic [N_PT-1:0] sel,
    output logic            sum
);
    assign sum = |(pt & sel);
endmodule

// File: rtl/ptl_reg_stage.sv
module ptl_reg_stage (
    input  logic reg_clk,
    input  logic reg_clr,
    input  logic d,
    output logic q
);
    always_ff @(posedge reg_clk or posedge reg_clr) begin
        if (reg_clr) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ptl_macrocell.sv
module ptl_macrocell
    import ptl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load_en,
    input  logic            cfg_sdi,
    input  logic [N_IN-1:0] pin_in,
    input  logic            glb_clr,
    output logic            cell_out,
    output logic            fb_out
);
    ptl_cfg_t        act_cfg;
    logic [N_PT-1:0] pt_vec;
    logic            sop;
    logic            reg_clk;
    logic            reg_clr;
    logic            reg_q;

    ptl_cfg_loader u_loader (
        .clk     (clk),
        .rst     (rst),
        .load_en (cfg_load_en),
        .sdi     (cfg_sdi),
        .act_cfg (act_cfg)
    );

    ptl_and_array u_and (
        .pin_in (pin_in),
        .mask   (act_cfg.and_mask),
        .pt     (pt_vec)
    );

    ptl_or_plane u_or (
        .pt  (pt_vec),
        .sel (act_cfg.or_sel),
        .sum (sop)
    );

    assign reg_clk = act_cfg.clk_sel ? pt_vec[CLK_PT] : clk;
    assign reg_clr = act_cfg.clr_sel ? pt_vec[CLR_PT] : glb_clr;

    ptl_reg_stage u_reg (
        .reg_clk (reg_clk),
        .reg_clr (reg_clr),
        .d       (sop),
        .q       (reg_q)
    );

    assign cell_out = act_cfg.bypass ? sop : reg_q;
    assign fb_out   = cell_out;
endmodule

// File: rtl/ptl_macrocell_chk.sv
module ptl_macrocell_chk
    import ptl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            load_en,
    input ptl_cfg_t        act_cfg,
    input logic [N_PT-1:0] pt,
    input logic            sum,
    input logic            clr_src,
    input logic            q,
    input logic            cell_out
);
    for (genvar p = 0; p < N_PT; p++) begin : g_empty
        AST_EMPTY_TERM_LOW: assert property (@(posedge clk) disable iff (rst)
            (act_cfg.and_mask[p] == '0) |-> !pt[p]); // R2
    end

    AST_NO_SELECT_LOW: assert property (@(posedge clk) disable iff (rst)
        (act_cfg.or_sel == '0) |-> !sum); // R3

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        act_cfg.bypass |-> (cell_out == sum)); // R4

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        clr_src |-> (q == 1'b0)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        load_en |=> $stable(act_cfg)); // R10
endmodule

bind ptl_macrocell ptl_macrocell_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (cfg_load_en),
    .act_cfg  (act_cfg),
    .pt       (pt_vec),
    .sum      (sop),
    .clr_src  (reg_clr),
    .q        (reg_q),
    .cell_out (cell_out)
);

// File: tb/tb_ptl_macrocell.sv
module tb_ptl_macrocell;
    import ptl_pkg::*;

    localparam int CLK_P  = 10;
    localparam int OR_B   = 40;
    localparam int CLKS_B = 45;
    localparam int CLRS_B = 46;
    localparam int BYP_B  = 47;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load_en = 1'b0;
    logic       cfg_sdi = 1'b0;
    logic [3:0] pin_in = 4'b0;
    logic       glb_clr = 1'b0;
    logic       cell_out;
    logic       fb_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  exp;
        string req;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;

    always #(CLK_P/2) clk = ~clk;

    ptl_macrocell dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_load_en (cfg_load_en),
        .cfg_sdi     (cfg_sdi),
        .pin_in      (pin_in),
        .glb_clr     (glb_clr),
        .cell_out    (cell_out),
        .fb_out      (fb_out)
    );

    // monitor: pops expected items and compares both outputs (fb_out per R9)
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (cell_out !== it.exp || fb_out !== it.exp) begin
                    n_err++;
                    $display("FAIL %s (R9 copy): cell_out=%b fb_out=%b expected %b",
                             it.req, cell_out, fb_out, it.exp);
                end
            end
        end
    end

    task automatic expect_out(input logic e, input string req);
        sb_item_t it;
        #1;
        it.exp = e;
        it.req = req;
        sb_q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    function automatic logic [CFG_W-1:0] link(input logic [CFG_W-1:0] v, input int p, input int c);
        logic [CFG_W-1:0] r;
        r = v;
        r[p*8+c] = 1'b1;
        return r;
    endfunction

    task automatic shift_bits(input logic [CFG_W-1:0] v, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            @(negedge clk);
            cfg_load_en = 1'b1;
            cfg_sdi     = v[i];
        end
    endtask

    task automatic finish_load();
        @(negedge clk);
        cfg_load_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [CFG_W-1:0] v);
        shift_bits(v, CFG_W-1, 0);
        finish_load();
    endtask

    function automatic logic f_ref(input logic [3:0] x);
        return (x[0] & x[2] & ~x[3]) | (x[1] & x[2] & ~x[3]);
    endfunction

    initial begin
        logic [CFG_W-1:0] cf;
        logic [CFG_W-1:0] cnext;

        // R11: reset state
        repeat (3) @(negedge clk);
        expect_out(1'b0, "R11 reset output");
        rst = 1'b0;
        @(negedge clk);
        expect_out(1'b0, "R11 after reset release");

        // R12 / R1 / R2 / R4: two-term example function, bypassed
        cf = '0;
        cf = link(cf, 0, 0); cf = link(cf, 0, 4); cf = link(cf, 0, 7);
        cf = link(cf, 1, 2); cf = link(cf, 1, 4); cf = link(cf, 1, 7);
        cf[OR_B+0] = 1'b1; cf[OR_B+1] = 1'b1; cf[BYP_B] = 1'b1;
        load_cfg(cf);
        for (int v = 0; v < 16; v++) begin
            pin_in = 4'(v);
            expect_out(f_ref(4'(v)), "R12 example function (R1 R4)");
        end

        // R2: empty term added to the selection changes nothing
        cf[OR_B+2] = 1'b1;
        load_cfg(cf);
        pin_in = 4'b1000;
        expect_out(1'b0, "R2 empty term stays low");
        pin_in = 4'b0101;
        expect_out(1'b1, "R2 linked terms still work");

        // R10: old function holds while half the new vector is shifted
        cnext = '0;
        cnext[BYP_B] = 1'b1;
        cnext[OR_B+2] = 1'b1;
        shift_bits(cnext, CFG_W-1, 24);
        pin_in = 4'b0110;
        expect_out(1'b1, "R10 old config during shift");
        pin_in = 4'b1110;
        expect_out(1'b0, "R10 old config during shift");
        shift_bits(cnext, 23, 0);
        @(negedge clk);
        cfg_load_en = 1'b0;
        pin_in = 4'b0101;
        expect_out(1'b1, "R10 old config until apply edge");
        @(negedge clk);
        expect_out(1'b0, "R2 only empty term selected");

        // R3: no term selected
        cnext = '0;
        cnext[BYP_B] = 1'b1;
        cnext = link(cnext, 0, 0);
        load_cfg(cnext);
        pin_in = 4'b1111;
        expect_out(1'b0, "R3 no selection gives 0");

        // R5: global clock register
        cf = '0;
        cf = link(cf, 0, 0);
        cf[OR_B+0] = 1'b1;
        pin_in = 4'b0000;
        load_cfg(cf);
        @(negedge clk);
        expect_out(1'b0, "R5 registered zero");
        pin_in = 4'b0001;
        expect_out(1'b0, "R5 holds before edge");
        @(negedge clk);
        expect_out(1'b1, "R5 captured on clk");
        pin_in = 4'b0000;
        expect_out(1'b1, "R5 holds between edges");
        @(negedge clk);
        expect_out(1'b0, "R5 captured zero");

        // R7: global asynchronous clear
        pin_in = 4'b0001;
        @(negedge clk);
        expect_out(1'b1, "R7 set up");
        #2 glb_clr = 1'b1;
        expect_out(1'b0, "R7 async clear");
        @(negedge clk);
        expect_out(1'b0, "R7 clear holds over edge");
        glb_clr = 1'b0;
        expect_out(1'b0, "R7 released before edge");
        @(negedge clk);
        expect_out(1'b1, "R7 recapture after release");

        // R6: local clock from term 3 (D true)
        cf = '0;
        cf = link(cf, 0, 0);
        cf = link(cf, 3, 6);
        cf[OR_B+0] = 1'b1;
        cf[CLKS_B] = 1'b1;
        pin_in = 4'b0000;
        load_cfg(cf);
        glb_clr = 1'b1;
        #2 glb_clr = 1'b0;
        expect_out(1'b0, "R6 cleared start");
        pin_in = 4'b0001;
        repeat (3) @(negedge clk);
        expect_out(1'b0, "R6 clk ignored");
        pin_in = 4'b1001;
        expect_out(1'b1, "R6 capture on local edge");
        pin_in = 4'b1000;
        expect_out(1'b1, "R6 hold without edge");
        pin_in = 4'b0000;
        expect_out(1'b1, "R6 falling edge no effect");
        pin_in = 4'b1000;
        expect_out(1'b0, "R6 capture zero on local edge");

        // R8: local clear from term 4 (C true)
        cf = '0;
        cf = link(cf, 0, 0);
        cf = link(cf, 4, 4);
        cf[OR_B+0] = 1'b1;
        cf[CLRS_B] = 1'b1;
        pin_in = 4'b0000;
        load_cfg(cf);
        pin_in = 4'b0001;
        @(negedge clk);
        expect_out(1'b1, "R8 set up");
        glb_clr = 1'b1;
        expect_out(1'b1, "R8 global clear ignored");
        @(negedge clk);
        expect_out(1'b1, "R8 global clear ignored over edge");
        glb_clr = 1'b0;
        pin_in = 4'b0101;
        expect_out(1'b0, "R8 local async clear");
        @(negedge clk);
        expect_out(1'b0, "R8 local clear holds");
        pin_in = 4'b0001;
        @(negedge clk);
        expect_out(1'b1, "R8 recapture after local clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule